// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Controller

This block sits between a free-running source clock and two groups of clock outputs. The bus group of six outputs can be parked by an active-low stop request. The auxiliary group of two outputs runs on regardless of that request. An active-low power-down request parks every output of both groups. Each request is asynchronous. Each one passes through a two-stage synchronizer clocked by the source clock before it can change anything.

Every output is the source clock ANDed with a per-output enable flop. That flop only updates on the falling edge of the source clock. So an enable only changes while the clock is low. A stopped output therefore sits low, and the first pulse after a restart is a whole high phase. Per-output mask inputs keep chosen outputs low whatever the requests do. Two status flags show when a group has no output running, which lets a bench measure stop and start latency at the ports.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While the reset input is low, every clock output is low and both idle flags are high.
- R2: No output is ever high while the source clock is low. A stopped or masked output is parked low, never high.
- R3: Suppose the stop request falls while the source clock is low, before rising edge P1. The enabled bus outputs still give full pulses at P1 and P2, and they stay low from P3 on.
- R4: Suppose the stop request rises while the source clock is low, before rising edge P1. The bus outputs stay low at P1 and P2. Their first pulse starts at P3, and that pulse is high for the whole high phase of the source clock.
- R5: The stop request has no effect on the auxiliary outputs.
- R6: Power-down follows the R3/R4 timing, but it applies to all outputs. While power-down is asserted, no level on the stop request can start any output.
- R7: Mask bit i at 0 keeps output i low. A mask change made while the clock is low takes effect at the next falling edge, so it first shows in the high phase after the following rising edge. Bit i of each mask goes with output i.
- R8: The bus idle flag is high exactly when no bus output is enabled. The all-idle flag is high exactly when no output of either group is enabled. Both flags change on the same falling edge as the enables they report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_stop_ni | input | 1 | Asynchronous active-low stop request for the bus group |
| pwr_down_ni | input | 1 | Asynchronous active-low power-down request for all outputs |
| bus_mask_i | input | 6 | Per-output enable mask for the bus group |
| aux_mask_i | input | 2 | Per-output enable mask for the auxiliary group |
| bus_clk_o | output | 6 | Gated bus clocks |
| aux_clk_o | output | 2 | Gated auxiliary clocks |
| bus_idle_o | output | 1 | High when no bus output is enabled |
| all_idle_o | output | 1 | High when no output of either group is enabled |

## Verification
The bench counts rising edges after each request change. A synchronizer that is one stage short, or an enable flop moved to the rising edge, would move the last or first pulse by a cycle. That error would also show up as a shortened high phase, which the two samples per high phase catch. The bench releases the stop request during power-down. A design that let the stop path override power-down would then restart the bus clocks early. Changes to the masks and checks on the auxiliary outputs during a bus stop expose any cross-coupling between the groups.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Group identifiers used to pick which requests gate a bank.
  typedef enum logic [0:0] {
    GRP_BUS = 1'b0,
    GRP_AUX = 1'b1
  } grp_kind_e;

  // Run condition of one group: power-down always gates, stop only gates the bus group.
  function automatic logic group_go(input grp_kind_e kind, input logic stop_run, input logic pd_run);
    return (kind == GRP_BUS) ? (stop_run & pd_run) : pd_run;
  endfunction

  // Next enable of one output lane.
  function automatic logic lane_run(input logic mask_bit, input logic grp_go);
    return mask_bit & grp_go;
  endfunction

endpackage

// File: rtl/req_sync.sv
`timescale 1ns/1ps
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  // Reset state reads as "request asserted" so outputs start only after sync fills.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[LAST-1:0], async_ni};
  end

  assign sync_no = chain_q[LAST];

  initial begin
    a_r3_sync_depth: assert (STAGES >= 2);
  end
endmodule

// File: rtl/gate_bank.sv
`timescale 1ns/1ps
module gate_bank #(
  parameter int LANES = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] clk_o,
  output logic [LANES-1:0] en_o,
  output logic             idle_o
);
  import clkstop_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic en_q;
    // Falling-edge enable: changes only while clk is low, so pulses are never cut.
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= lane_run(mask_i[g], go_i);
    end
    assign en_o[g]  = en_q;
    assign clk_o[g] = clk_i & en_q;
  end

  assign idle_o = (en_o == '0);

  // R2: sampled just before a rising edge (clock low), every gated output is low.
  a_r2_park_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == '0);

  // R7: a lane whose mask has been low across a whole cycle is never enabled.
  a_r7_mask_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mask_i) |-> ((en_o & ~mask_i) == '0));
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int BUS_LANES   = 6,
  parameter int AUX_LANES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_src_i,
  input  logic                 rst_ni,
  input  logic                 bus_stop_ni,
  input  logic                 pwr_down_ni,
  input  logic [BUS_LANES-1:0] bus_mask_i,
  input  logic [AUX_LANES-1:0] aux_mask_i,
  output logic [BUS_LANES-1:0] bus_clk_o,
  output logic [AUX_LANES-1:0] aux_clk_o,
  output logic                 bus_idle_o,
  output logic                 all_idle_o
);
  import clkstop_pkg::*;

  logic stop_run;   // synchronized, high = bus may run
  logic pd_run;     // synchronized, high = not powered down
  logic bus_go;
  logic aux_go;
  logic [BUS_LANES-1:0] bus_en;
  logic [AUX_LANES-1:0] aux_en;
  logic aux_idle;

  req_sync #(.STAGES(SYNC_STAGES)) i_stop_sync (
    .clk_i(clk_src_i), .rst_ni(rst_ni), .async_ni(bus_stop_ni), .sync_no(stop_run));

  req_sync #(.STAGES(SYNC_STAGES)) i_pd_sync (
    .clk_i(clk_src_i), .rst_ni(rst_ni), .async_ni(pwr_down_ni), .sync_no(pd_run));

  assign bus_go = group_go(GRP_BUS, stop_run, pd_run);
  assign aux_go = group_go(GRP_AUX, stop_run, pd_run);

  gate_bank #(.LANES(BUS_LANES)) i_bus_bank (
    .clk_i(clk_src_i), .rst_ni(rst_ni), .go_i(bus_go), .mask_i(bus_mask_i),
    .clk_o(bus_clk_o), .en_o(bus_en), .idle_o(bus_idle_o));

  gate_bank #(.LANES(AUX_LANES)) i_aux_bank (
    .clk_i(clk_src_i), .rst_ni(rst_ni), .go_i(aux_go), .mask_i(aux_mask_i),
    .clk_o(aux_clk_o), .en_o(aux_en), .idle_o(aux_idle));

  assign all_idle_o = bus_idle_o & aux_idle;

  // R3: once the synchronized stop has been seen at an edge, the bus enables are already cleared.
  a_r3_bus_off: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    !stop_run |-> (bus_en == '0));

  // R4: a running bus group with a steady mask has exactly the mask enabled.
  a_r4_bus_on: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    (bus_go && $stable(bus_mask_i)) |-> (bus_en == bus_mask_i));

  // R6: power-down clears both groups regardless of the stop request.
  a_r6_pd_all: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    !pd_run |-> ((bus_en == '0) && (aux_en == '0)));

  // R5: the stop request alone never disables an unmasked auxiliary lane.
  a_r5_aux_free: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    (pd_run && $stable(aux_mask_i)) |-> (aux_en == aux_mask_i));
endmodule

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/1ps
module test_clk_stop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_n = 1'b1;
  logic       pd_n = 1'b1;
  logic [5:0] bmask = 6'h3F;
  logic [1:0] amask = 2'h3;
  logic [5:0] bclk;
  logic [1:0] aclk;
  logic       bidle, aidle;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  clk_stop_ctrl i_clk_stop_ctrl (
    .clk_src_i(clk), .rst_ni(rst_n), .bus_stop_ni(stop_n), .pwr_down_ni(pd_n),
    .bus_mask_i(bmask), .aux_mask_i(amask), .bus_clk_o(bclk), .aux_clk_o(aclk),
    .bus_idle_o(bidle), .all_idle_o(aidle));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive point: clock low, ahead of the next rising edge (P1).
  task automatic low_phase();
    @(negedge clk); #1;
  endtask

  // Move to 0.5 ns after the next rising edge (early high phase).
  task automatic rise_early();
    @(posedge clk); #0.5;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rise_early();
    chk("R1", "bus in reset", bclk, 6'h00);
    chk("R1", "aux in reset", aclk, 2'h0);
    chk("R1", "idle flags in reset", {bidle, aidle}, 2'b11);
    low_phase();
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #0.5;
    chk("R4", "bus running after reset", bclk, 6'h3F);
    #1.0;
    chk("R4", "bus late high phase", bclk, 6'h3F);
    chk("R5", "aux running", aclk, 2'h3);
    @(negedge clk); #1;
    chk("R2", "bus low in low phase", {aclk, bclk}, 8'h00);
  endtask

  task automatic t_stop();
    low_phase();
    stop_n = 1'b0;
    rise_early(); chk("R3", "pulse at P1", bclk, 6'h3F);
    rise_early(); chk("R3", "pulse at P2", bclk, 6'h3F);
    #1.0;         chk("R3", "P2 pulse full width", bclk, 6'h3F);
    chk("R8", "bus idle low while running", bidle, 1'b0);
    rise_early(); chk("R3", "stopped at P3", bclk, 6'h00);
    chk("R5", "aux runs during stop", aclk, 2'h3);
    chk("R8", "bus idle at P3", bidle, 1'b1);
    chk("R8", "all idle stays low", aidle, 1'b0);
    repeat (3) rise_early();
    chk("R3", "stays stopped", bclk, 6'h00);
  endtask

  task automatic t_start();
    low_phase();
    stop_n = 1'b1;
    rise_early(); chk("R4", "low at P1", bclk, 6'h00);
    rise_early(); chk("R4", "low at P2", bclk, 6'h00);
    rise_early(); chk("R4", "first pulse early", bclk, 6'h3F);
    #1.0;         chk("R4", "first pulse late", bclk, 6'h3F);
    chk("R8", "bus idle cleared", bidle, 1'b0);
  endtask

  task automatic t_mask();
    low_phase();
    bmask = 6'b010101;
    amask = 2'b10;
    rise_early(); chk("R7", "old mask at P1", bclk, 6'h3F);
    rise_early(); chk("R7", "bus mask at P2", bclk, 6'b010101);
    chk("R7", "aux mask at P2", aclk, 2'b10);
    low_phase();
    bmask = 6'h00;
    repeat (2) rise_early();
    chk("R7", "all bus masked", bclk, 6'h00);
    chk("R8", "bus idle by mask", bidle, 1'b1);
    chk("R8", "all idle low, aux on", aidle, 1'b0);
    low_phase();
    bmask = 6'h3F;
    amask = 2'h3;
    repeat (2) rise_early();
    chk("R7", "mask restored", {aclk, bclk}, 8'hFF);
  endtask

  task automatic t_pd();
    low_phase();
    pd_n = 1'b0;
    rise_early(); chk("R6", "pd pulse at P1", {aclk, bclk}, 8'hFF);
    rise_early(); chk("R6", "pd pulse at P2", {aclk, bclk}, 8'hFF);
    rise_early(); chk("R6", "pd stopped at P3", {aclk, bclk}, 8'h00);
    chk("R8", "all idle in pd", aidle, 1'b1);
    low_phase();
    stop_n = 1'b0;
    repeat (3) rise_early();
    low_phase();
    stop_n = 1'b1;
    repeat (4) rise_early();
    chk("R6", "stop release ignored in pd", {aclk, bclk}, 8'h00);
    low_phase();
    pd_n = 1'b1;
    rise_early(); chk("R6", "still low at P1", {aclk, bclk}, 8'h00);
    rise_early(); chk("R6", "still low at P2", {aclk, bclk}, 8'h00);
    rise_early(); chk("R6", "restart at P3", {aclk, bclk}, 8'hFF);
    #1.0;         chk("R6", "restart pulse full", {aclk, bclk}, 8'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_stop();
    t_start();
    t_mask();
    t_pd();
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule